// File: doc/BRIEF.md
# Dual-Port Message Mailbox with Hardware Locks

Two processors, an application side and a microcontroller side, each reach this register block through a simple synchronous register port of their own. The block holds four message slots. A slot carries a 32-bit payload word and a 32-bit command word, plus one pending bit. The sender writes the payload first and then the command. Writing the command raises the pending bit. When its enable is set, the pending bit drives an interrupt line toward the receiver. The receiver reads the words and then clears the pending bit by writing a one to it.

A bank of 32 single-bit locks lets software on either side claim a shared resource. A read of a free lock grabs it in the same access and returns 0. A read of a held lock returns 1 and changes nothing. A write with bit 0 set frees the lock. Reads have a side effect, so read data is registered: it appears on the port's read-data output in the cycle after the access and holds until the next read on that port.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, all payload, command, pending and enable state is zero, all locks are free, both read-data outputs are 0, and no interrupt output is high.
- R2: Word addresses 0..3 hold the payload word of slots 0..3 and addresses 4..7 hold their command words. Either port can write them and either port can read them, and a read returns its value on that port's rdata one cycle after the access.
- R3: A write to the command word of slot i sets pending bit i. The pending bits read back as bits 3:0 at address 8.
- R4: A write to address 8 clears each pending bit whose data bit is 1 and leaves the others. A command write that sets a bit in the same cycle as a clear of that bit leaves it set.
- R5: Bits 3:0 at address 9 are per-slot interrupt enables. irq_slot[i] is pending[i] AND enable[i], and irq_any is the OR of irq_slot.
- R6: A read of address 32+k returns 0 and takes lock k if lock k is free, and returns 1 with no change if lock k is held.
- R7: A write to address 32+k with data bit 0 equal to 1 frees lock k. A write with bit 0 equal to 0 leaves it as it was.
- R8: When both ports read the same free lock in one cycle, port A gets 0 and owns the lock, and port B gets 1.
- R9: When both ports write the same message or enable register in one cycle, port A's value is kept.
- R10: Reads of addresses 10..31 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_req | input | 1 | Port A access strobe |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_addr | input | 6 | Port A word address |
| a_wdata | input | 32 | Port A write data |
| a_rdata | output | 32 | Port A read data, valid the cycle after a read |
| b_req | input | 1 | Port B access strobe |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_addr | input | 6 | Port B word address |
| b_wdata | input | 32 | Port B write data |
| b_rdata | output | 32 | Port B read data, valid the cycle after a read |
| irq_slot | output | 4 | Per-slot interrupt, pending AND enable |
| irq_any | output | 1 | OR of all slot interrupts |

## Verification
The bench visits every lock from both ports and targets the two cases a careless lock would get wrong. One is a simultaneous read of the same lock: a design without a tie-break would hand the lock to both sides. The other is a release written with bit 0 clear: a design that ignored the data bit would drop the lock. All 256 combinations of pending bits and enables are swept, so a design that mixed up the gating would raise an interrupt on a masked slot. A command write landing in the same cycle as a clear shows whether a new message gets lost. A status write of zero shows whether a design treats the status register as a plain store and wipes the pending bits.

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int DW     = 32,
  parameter int N_SLOT = 4,
  parameter int N_LOCK = 32,
  parameter int AW     = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_req,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_req,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic [N_SLOT-1:0] irq_slot,
  output logic          irq_any
);
  localparam int LW = (N_LOCK > 1) ? $clog2(N_LOCK) : 1;
  localparam logic [AW-1:0] STAT = AW'(2*N_SLOT);
  localparam logic [AW-1:0] IEN  = AW'(2*N_SLOT+1);

  logic [N_SLOT-1:0][DW-1:0] pay_q, cmd_q;
  logic [N_SLOT-1:0] pend_q, ien_q, set_v, clr_v;
  logic [N_LOCK-1:0] lock_q, acq_v, rel_v;

  wire a_wr = a_req & a_we;
  wire b_wr = b_req & b_we;
  wire a_lk = a_addr[AW-1] && (32'(a_addr[AW-2:0]) < N_LOCK);
  wire b_lk = b_addr[AW-1] && (32'(b_addr[AW-2:0]) < N_LOCK);
  wire [LW-1:0] a_idx = a_addr[LW-1:0];
  wire [LW-1:0] b_idx = b_addr[LW-1:0];
  wire a_lrd = a_req & ~a_we & a_lk;
  wire b_lrd = b_req & ~b_we & b_lk;
  wire tie   = a_lrd & b_lrd & (a_idx == b_idx);

  always_comb begin
    set_v = '0;
    for (int i = 0; i < N_SLOT; i++)
      set_v[i] = (a_wr && a_addr == AW'(N_SLOT+i)) || (b_wr && b_addr == AW'(N_SLOT+i));
    clr_v = (a_wr && a_addr == STAT ? a_wdata[N_SLOT-1:0] : '0) |
            (b_wr && b_addr == STAT ? b_wdata[N_SLOT-1:0] : '0);
    acq_v = '0;
    rel_v = '0;
    if (a_lrd && !lock_q[a_idx]) acq_v[a_idx] = 1'b1;
    if (b_lrd && !lock_q[b_idx] && !tie) acq_v[b_idx] = 1'b1;
    if (a_wr && a_lk && a_wdata[0]) rel_v[a_idx] = 1'b1;
    if (b_wr && b_lk && b_wdata[0]) rel_v[b_idx] = 1'b1;
  end

  function automatic logic [DW-1:0] rd(input logic [AW-1:0] ad,
      input logic [N_SLOT-1:0][DW-1:0] p, input logic [N_SLOT-1:0][DW-1:0] c,
      input logic [N_SLOT-1:0] f, input logic [N_SLOT-1:0] e,
      input logic [N_LOCK-1:0] lk);
    logic [DW-1:0] r;
    r = '0;
    if (ad[AW-1]) begin
      if (32'(ad[AW-2:0]) < N_LOCK) r[0] = lk[ad[LW-1:0]];
    end else if (32'(ad) < N_SLOT) r = p[32'(ad)];
    else if (32'(ad) < 2*N_SLOT) r = c[32'(ad) - N_SLOT];
    else if (ad == STAT) r[N_SLOT-1:0] = f;
    else if (ad == IEN)  r[N_SLOT-1:0] = e;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pay_q <= '0; cmd_q <= '0; pend_q <= '0; ien_q <= '0;
      lock_q <= '0; a_rdata <= '0; b_rdata <= '0;
    end else begin
      for (int i = 0; i < N_SLOT; i++) begin
        if (a_wr && a_addr == AW'(i)) pay_q[i] <= a_wdata;
        else if (b_wr && b_addr == AW'(i)) pay_q[i] <= b_wdata;
        if (a_wr && a_addr == AW'(N_SLOT+i)) cmd_q[i] <= a_wdata;
        else if (b_wr && b_addr == AW'(N_SLOT+i)) cmd_q[i] <= b_wdata;
      end
      if (a_wr && a_addr == IEN) ien_q <= a_wdata[N_SLOT-1:0];
      else if (b_wr && b_addr == IEN) ien_q <= b_wdata[N_SLOT-1:0];
      pend_q <= (pend_q & ~clr_v) | set_v;
      lock_q <= (lock_q & ~rel_v) | acq_v;
      if (a_req && !a_we) a_rdata <= rd(a_addr, pay_q, cmd_q, pend_q, ien_q, lock_q);
      if (b_req && !b_we) b_rdata <= rd(b_addr, pay_q, cmd_q, pend_q, ien_q, lock_q) | DW'(tie);
    end
  end

  assign irq_slot = pend_q & ien_q;
  assign irq_any  = |irq_slot;

  p_lock_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_lrd && !lock_q[a_idx]) |=> (a_rdata == '0) && lock_q[$past(a_idx)]);
  p_lock_tie_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tie |=> b_rdata[0] && lock_q[$past(b_idx)]);
  p_lock_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr && a_lk && a_wdata[0] && !(b_lrd && b_idx == a_idx)) |=> !lock_q[$past(a_idx)]);
  p_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (b_lrd && lock_q[b_idx]) |=> b_rdata[0]);
  for (genvar g = 0; g < N_SLOT; g++) begin : g_chk
    p_cmd_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (b_wr && b_addr == AW'(N_SLOT+g)) |=> pend_q[g]);
    p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[g] && !(a_wr && a_addr == STAT && a_wdata[g]) &&
       !(b_wr && b_addr == STAT && b_wdata[g])) |=> pend_q[g]);
  end
endmodule

// File: tb/ipc_mailbox_bench.sv
`timescale 1ns/1ps
module ipc_mailbox_bench;
  logic clk = 0, rst_n = 0;
  logic a_req = 0, a_we = 0, b_req = 0, b_we = 0;
  logic [5:0] a_addr = 0, b_addr = 0;
  logic [31:0] a_wdata = 0, b_wdata = 0, a_rdata, b_rdata;
  logic [3:0] irq_slot;
  logic irq_any;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  ipc_mailbox u_ipc_mailbox (.clk(clk), .rst_n(rst_n),
    .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .irq_slot(irq_slot), .irq_any(irq_any));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic ae, input logic awe, input logic [5:0] aad, input logic [31:0] awd,
                     input logic be, input logic bwe, input logic [5:0] bad_, input logic [31:0] bwd,
                     output logic [31:0] ard, output logic [31:0] brd);
    @(negedge clk);
    a_req = ae; a_we = awe; a_addr = aad; a_wdata = awd;
    b_req = be; b_we = bwe; b_addr = bad_; b_wdata = bwd;
    @(negedge clk);
    a_req = 0; b_req = 0;
    ard = a_rdata; brd = b_rdata;
  endtask

  task automatic wr(input bit port, input logic [5:0] ad, input logic [31:0] d);
    logic [31:0] x, y;
    if (port == 0) acc(1, 1, ad, d, 0, 0, 0, 0, x, y);
    else           acc(0, 0, 0, 0, 1, 1, ad, d, x, y);
  endtask

  task automatic rdp(input bit port, input logic [5:0] ad, output logic [31:0] r);
    logic [31:0] x, y;
    if (port == 0) begin acc(1, 0, ad, 0, 0, 0, 0, 0, x, y); r = x; end
    else begin acc(0, 0, 0, 0, 1, 0, ad, 0, x, y); r = y; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r, r2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 a_rdata", a_rdata, 0);
    chk("R1 b_rdata", b_rdata, 0);
    chk("R1 irq", {27'd0, irq_any, irq_slot}, 0);
    for (int k = 0; k < 10; k++) begin rdp(k % 2, 6'(k), r); chk("R1 reg", r, 0); end
    rdp(0, 6'd40, r); chk("R1 lock free", r, 0);
    wr(0, 6'd40, 1);

    for (int i = 0; i < 4; i++)
      for (int p = 0; p < 2; p++) begin
        logic [31:0] dv, cv;
        dv = 32'hA5000000 ^ (i << 8) ^ p;
        cv = 32'h3C000000 ^ (i << 12) ^ (p << 4);
        wr(p[0], 6'(i), dv);
        rdp(p[0], 6'd8, r); chk("R3 no flag before cmd", r & (1 << i), 0);
        wr(p[0], 6'(4 + i), cv);
        rdp(!p[0], 6'(i), r); chk("R2 payload", r, dv);
        rdp(!p[0], 6'(4 + i), r); chk("R2 command", r, cv);
        rdp(!p[0], 6'd8, r); chk("R3 flag", r, 32'(1 << i));
        wr(!p[0], 6'd8, 0);
        rdp(p[0], 6'd8, r); chk("R4 zero write keeps", r, 32'(1 << i));
        wr(!p[0], 6'd8, 32'hF);
        rdp(p[0], 6'd8, r); chk("R4 clear", r, 0);
      end

    for (int f = 0; f < 16; f++)
      for (int e = 0; e < 16; e++) begin
        wr(e % 2, 6'd9, 32'(e));
        for (int i = 0; i < 4; i++) if (f[i]) wr(f % 2, 6'(4 + i), 32'(f));
        chk("R5 irq_slot", {28'd0, irq_slot}, 32'(f & e));
        chk("R5 irq_any", {31'd0, irq_any}, 32'((f & e) != 0));
        rdp(0, 6'd8, r); chk("R3 status", r, 32'(f));
        wr(1, 6'd8, 32'hF);
        chk("R4 irq cleared", {28'd0, irq_slot}, 0);
      end

    wr(0, 6'd6, 1);
    acc(1, 1, 6'd6, 32'h77, 1, 1, 6'd8, 32'hF, r, r2);
    rdp(1, 6'd8, r); chk("R4 set beats clear", r, 32'h4);
    rdp(1, 6'd6, r); chk("R2 cmd kept", r, 32'h77);
    wr(0, 6'd8, 32'hF);

    acc(1, 1, 6'd2, 32'h1111, 1, 1, 6'd2, 32'h2222, r, r2);
    rdp(1, 6'd2, r); chk("R9 payload A wins", r, 32'h1111);
    acc(1, 1, 6'd9, 32'h5, 1, 1, 6'd9, 32'hA, r, r2);
    rdp(0, 6'd9, r); chk("R9 enable A wins", r, 32'h5);
    wr(0, 6'd9, 0);

    for (int k = 10; k < 32; k++) begin rdp(k % 2, 6'(k), r); chk("R10 unmapped", r, 0); end

    for (int k = 0; k < 32; k++)
      for (int p = 0; p < 2; p++) begin
        rdp(p[0], 6'(32 + k), r); chk("R6 take free", r, 0);
        rdp(!p[0], 6'(32 + k), r); chk("R6 held", r, 1);
        wr(!p[0], 6'(32 + k), 32'hFFFFFFFE);
        rdp(p[0], 6'(32 + k), r); chk("R7 bit0 zero keeps", r, 1);
        wr(!p[0], 6'(32 + k), 1);
        rdp(!p[0], 6'(32 + k), r); chk("R7 freed", r, 0);
        wr(p[0], 6'(32 + k), 1);
      end

    for (int k = 0; k < 32; k++) begin
      acc(1, 0, 6'(32 + k), 0, 1, 0, 6'(32 + k), 0, r, r2);
      chk("R8 A wins", r, 0);
      chk("R8 B loses", r2, 1);
      rdp(1, 6'(32 + k), r); chk("R8 A owns", r, 1);
      wr(0, 6'(32 + k), 1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule